// File: doc/BRIEF.md
# Bresenham Line Stepper

This block walks a straight line one pixel per clock. The host works out the step constants itself and loads them with a start strobe: the start point, an axial increment, a diagonal increment, the initial error, and the number of pixels along the major axis. The block latches these values together with a small set of mode bits. The mode bits choose which axis is major, the stepping direction on each axis, whether the final pixel is dropped, and whether pixels are produced at all.

While the walk runs, the block presents one coordinate per cycle on registered outputs, with a valid flag beside it. The major coordinate moves by one on every step. The sign of the running error decides whether the minor coordinate also moves. That same decision selects which constant is added to the error. After the last coordinate, a single-cycle done pulse marks the end. The host then needs no knowledge of endpoints inside the block, only the precomputed constants.

Top module: `line_stepper`

## Requirements
- R1: Reset sets the outputs to a known state: `busy`, `pix_valid` and `done` are all low.
- R2: A `start` strobe that is sampled while `busy` is low latches every operand. The first coordinate, equal to (`start_x`, `start_y`), appears on the outputs two clock edges after the edge that sampled `start`. Further coordinates follow on consecutive cycles, exactly `major_len` of them.
- R3: `major_y` = 1 makes Y the major axis and `major_y` = 0 makes X the major axis. The major coordinate changes by exactly one between consecutive coordinates.
- R4: The error is treated as CW-bit two's complement. When it is zero or positive, the step is diagonal: both coordinates move and `diag_step` is added to the error. When it is negative, the step is axial: only the major coordinate moves and `axial_step` is added. The error starts at `err_init`.
- R5: `dir_right` = 1 makes X increase and `dir_right` = 0 makes X decrease. `dir_down` = 1 makes Y increase and `dir_down` = 0 makes Y decrease.
- R6: With `last_off` = 1, the final coordinate of the walk is presented with `pix_valid` low. All earlier coordinates are still valid.
- R7: With `draw_en` = 0, `pix_valid` stays low for the whole walk. The coordinates still advance, and the walk takes the same number of cycles and ends with `done`.
- R8: `done` is high for exactly one cycle. That cycle is the one right after the cycle that shows the last coordinate, and `busy` is low in it. A `start` strobe sampled in that cycle is accepted.
- R9: A `start` strobe sampled while `busy` is high is ignored. The current walk continues with its latched operands.
- R10: `major_len` = 0 produces no coordinates, and `done` pulses two edges after the sampling edge.
- R11: Coordinate and error arithmetic wraps modulo 2^CW. For example, X stepping right from 16'h7FFF gives 16'h8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (ignored while busy) |
| start_x | input | CW | First X coordinate |
| start_y | input | CW | First Y coordinate |
| axial_step | input | CW | Error increment for an axial step |
| diag_step | input | CW | Error increment for a diagonal step |
| err_init | input | CW | Initial error term |
| major_len | input | LW | Pixel count along the major axis |
| major_y | input | 1 | 1: Y is the major axis |
| dir_right | input | 1 | 1: X increases, 0: X decreases |
| dir_down | input | 1 | 1: Y increases, 0: Y decreases |
| last_off | input | 1 | Suppress the final pixel |
| draw_en | input | 1 | 0: move only, no valid pixels |
| busy | output | 1 | Walk in progress |
| pix_valid | output | 1 | Coordinate on pix_x/pix_y is a pixel to draw |
| pix_x | output | CW | Current X coordinate |
| pix_y | output | CW | Current Y coordinate |
| done | output | 1 | One-cycle pulse after the last coordinate |

## Verification
Two events can fall in the same cycle: the done pulse of one walk and the start strobe of the next. The bench provokes this by raising `start` in the very cycle it observes `done`. It then confirms that the new line's first coordinate arrives two edges later and that the second walk matches the model pixel by pixel. A second overlap is a start strobe placed in the middle of a walk, carrying a different start X. It is judged by checking that every later coordinate still follows the first line's latched operands.

// File: rtl/lstep_pkg.sv
package lstep_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_FIN  = 2'd2
  } lstep_state_e;

  typedef struct packed {
    logic major_y;
    logic dir_right;
    logic dir_down;
    logic last_off;
    logic draw_en;
  } lstep_mode_t;

endpackage

// File: rtl/lstep_ctrl.sv
module lstep_ctrl
  import lstep_pkg::*;
#(
  parameter int LW = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [LW-1:0] major_len,
  input  lstep_mode_t mode_in,
  output logic        load,
  output logic        step,
  output logic        last,
  output logic        fin,
  output logic        busy,
  output lstep_mode_t mode_q
);
  localparam logic [LW-1:0] ONE = {{(LW-1){1'b0}}, 1'b1};

  lstep_state_e state;
  logic [LW-1:0] remain;

  assign load = start && (state == ST_IDLE);
  assign step = (state == ST_WALK);
  assign last = step && (remain == ONE);
  assign fin  = (state == ST_FIN);
  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      remain <= '0;
      mode_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          mode_q <= mode_in;
          remain <= major_len;
          state  <= (major_len == '0) ? ST_FIN : ST_WALK;
        end
        ST_WALK: begin
          remain <= remain - ONE;
          if (remain == ONE) state <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: an ongoing walk keeps counting down regardless of start
  a_r9_walk_continues: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WALK && remain != ONE) |=> (state == ST_WALK && remain == $past(remain) - ONE));

  // R10: zero length goes straight to the finishing state
  a_r10_zero_len: assert property (@(posedge clk) disable iff (rst)
    (load && major_len == '0) |=> fin);

  // R8: finishing state lasts one cycle
  a_r8_fin_once: assert property (@(posedge clk) disable iff (rst)
    fin |=> !busy);

endmodule

// File: rtl/lstep_err.sv
module lstep_err #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] err_init,
  input  logic [W-1:0] axial_in,
  input  logic [W-1:0] diag_in,
  output logic         diag_go
);
  localparam int MSB = W - 1;

  logic [W-1:0] err_q, axial_q, diag_q;

  assign diag_go = ~err_q[MSB];

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q   <= '0;
      axial_q <= '0;
      diag_q  <= '0;
    end else if (load) begin
      err_q   <= err_init;
      axial_q <= axial_in;
      diag_q  <= diag_in;
    end else if (step) begin
      err_q <= err_q + (diag_go ? diag_q : axial_q);
    end
  end

  // R4: increments stay fixed for the whole walk
  a_r4_consts_held: assert property (@(posedge clk) disable iff (rst)
    ($past(step) && !$past(load)) |-> ($stable(axial_q) && $stable(diag_q)));

endmodule

// File: rtl/lstep_axis.sv
module lstep_axis #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] init_pos,
  input  logic         step,
  input  logic         adv,
  input  logic         fwd,
  output logic [W-1:0] pos
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)              pos <= '0;
    else if (load)        pos <= init_pos;
    else if (step && adv) pos <= fwd ? pos + ONE : pos - ONE;
  end

  // R5: an advancing axis moves one unit in its commanded direction
  a_r5_dir_move: assert property (@(posedge clk) disable iff (rst)
    (step && adv) |=> (pos == (fwd ? $past(pos) + ONE : $past(pos) - ONE)));

  // R4: a held axis does not move
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (step && !adv && !load) |=> $stable(pos));

endmodule

// File: rtl/line_stepper.sv
module line_stepper
  import lstep_pkg::*;
#(
  parameter int CW = 16,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] start_x,
  input  logic [CW-1:0] start_y,
  input  logic [CW-1:0] axial_step,
  input  logic [CW-1:0] diag_step,
  input  logic [CW-1:0] err_init,
  input  logic [LW-1:0] major_len,
  input  logic          major_y,
  input  logic          dir_right,
  input  logic          dir_down,
  input  logic          last_off,
  input  logic          draw_en,
  output logic          busy,
  output logic          pix_valid,
  output logic [CW-1:0] pix_x,
  output logic [CW-1:0] pix_y,
  output logic          done
);
  localparam int NAX = 2;
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  lstep_mode_t mode_in, mode_q;
  logic load, step, last, fin, diag_go;
  logic [CW-1:0] init_pos [NAX];
  logic [CW-1:0] pos      [NAX];

  assign mode_in = '{major_y: major_y, dir_right: dir_right, dir_down: dir_down,
                     last_off: last_off, draw_en: draw_en};
  assign init_pos[0] = start_x;
  assign init_pos[1] = start_y;

  lstep_ctrl #(.LW(LW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .major_len(major_len), .mode_in(mode_in),
    .load(load), .step(step), .last(last), .fin(fin), .busy(busy), .mode_q(mode_q)
  );

  lstep_err #(.W(CW)) u_err (
    .clk(clk), .rst(rst), .load(load), .step(step), .err_init(err_init),
    .axial_in(axial_step), .diag_in(diag_step), .diag_go(diag_go)
  );

  for (genvar a = 0; a < NAX; a++) begin : g_axis
    localparam bit IS_Y = (a == 1);
    logic adv_a, fwd_a;
    assign adv_a = (mode_q.major_y == IS_Y) ? 1'b1 : diag_go;
    assign fwd_a = IS_Y ? mode_q.dir_down : mode_q.dir_right;
    lstep_axis #(.W(CW)) u_axis (
      .clk(clk), .rst(rst), .load(load), .init_pos(init_pos[a]),
      .step(step), .adv(adv_a), .fwd(fwd_a), .pos(pos[a])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_valid <= 1'b0;
      pix_x     <= '0;
      pix_y     <= '0;
      done      <= 1'b0;
    end else begin
      done <= fin;
      if (step) begin
        pix_valid <= mode_q.draw_en && !(last && mode_q.last_off);
        pix_x     <= pos[0];
        pix_y     <= pos[1];
      end else begin
        pix_valid <= 1'b0;
      end
    end
  end

  // R8: done is a single-cycle pulse with the block idle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !pix_valid));

  // R7: move-only walks never flag a pixel
  a_r7_no_draw: assert property (@(posedge clk) disable iff (rst)
    (busy && !mode_q.draw_en) |=> !pix_valid);

  // R4: a diagonal decision moves both axes
  a_r4_diag_both: assert property (@(posedge clk) disable iff (rst)
    (step && diag_go) |=> (pos[0] != $past(pos[0]) && pos[1] != $past(pos[1])));

  // R3: successive valid pixels are neighbours
  a_r3_adjacent: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && $past(pix_valid)) |->
      ((pix_x == $past(pix_x) || pix_x == $past(pix_x) + ONE || pix_x == $past(pix_x) - ONE) &&
       (pix_y == $past(pix_y) || pix_y == $past(pix_y) + ONE || pix_y == $past(pix_y) - ONE)));

endmodule

// File: tb/tb_line_stepper.sv
`timescale 1ns/1ps
module tb_line_stepper;
  localparam int CW = 16;
  localparam int LW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic start = 1'b0;
  logic [CW-1:0] start_x = '0, start_y = '0, axial_step = '0, diag_step = '0, err_init = '0;
  logic [LW-1:0] major_len = '0;
  logic major_y = 1'b0, dir_right = 1'b0, dir_down = 1'b0, last_off = 1'b0, draw_en = 1'b0;
  logic busy, pix_valid, done;
  logic [CW-1:0] pix_x, pix_y;

  line_stepper #(.CW(CW), .LW(LW)) dut (
    .clk(clk), .rst(rst), .start(start), .start_x(start_x), .start_y(start_y),
    .axial_step(axial_step), .diag_step(diag_step), .err_init(err_init),
    .major_len(major_len), .major_y(major_y), .dir_right(dir_right), .dir_down(dir_down),
    .last_off(last_off), .draw_en(draw_en), .busy(busy), .pix_valid(pix_valid),
    .pix_x(pix_x), .pix_y(pix_y), .done(done)
  );

  int n_run = 0;
  int n_fail = 0;

  logic [CW-1:0] m_sx, m_sy, m_ax, m_dg, m_e0;
  int m_len;
  bit m_my, m_dr, m_dd, m_lo, m_de;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // caller is at a negedge; start is sampled at the next posedge
  task automatic launch(input logic [CW-1:0] sx, input logic [CW-1:0] sy,
                        input logic [CW-1:0] ax, input logic [CW-1:0] dg,
                        input logic [CW-1:0] e0, input int len,
                        input bit my, input bit dr, input bit dd, input bit lo, input bit de);
    start_x = sx; start_y = sy; axial_step = ax; diag_step = dg; err_init = e0;
    major_len = LW'(len); major_y = my; dir_right = dr; dir_down = dd;
    last_off = lo; draw_en = de; start = 1'b1;
    m_sx = sx; m_sy = sy; m_ax = ax; m_dg = dg; m_e0 = e0; m_len = len;
    m_my = my; m_dr = dr; m_dd = dd; m_lo = lo; m_de = de;
  endtask

  function automatic logic [CW-1:0] mv(input logic [CW-1:0] v, input bit fwd);
    return fwd ? v + 1'b1 : v - 1'b1;
  endfunction

  // Walk the model alongside the DUT; returns at negedge of the done cycle
  task automatic check_walk(input int glitch_at);
    logic [CW-1:0] x, y, e;
    bit ev, dg;
    string rq;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    x = m_sx; y = m_sy; e = m_e0;
    for (int i = 0; i < m_len; i++) begin
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      ev = m_de && !(i == m_len - 1 && m_lo);
      rq = !m_de ? "R7" : ((i == m_len - 1 && m_lo) ? "R6" : "R2");
      chk(pix_valid == ev, rq, "pix_valid", pix_valid, ev);
      chk(pix_x == x, m_my ? "R4" : "R5", "pix_x", pix_x, x);
      chk(pix_y == y, m_my ? "R5" : "R4", "pix_y", pix_y, y);
      chk(!done, "R8", "done low mid-walk", done, 0);
      if (i == glitch_at) begin
        start = 1'b1;                      // R9: strobe while busy
        start_x = CW'($urandom);
      end
      dg = !e[CW-1];
      if (m_my) begin
        y = mv(y, m_dd);
        if (dg) x = mv(x, m_dr);
      end else begin
        x = mv(x, m_dr);
        if (dg) y = mv(y, m_dd);
      end
      e = e + (dg ? m_dg : m_ax);
    end
    @(posedge clk); @(negedge clk);
    chk(done == 1'b1, (m_len == 0) ? "R10" : "R8", "done pulse", done, 1);
    chk(busy == 1'b0, "R8", "busy in done cycle", busy, 0);
    chk(pix_valid == 1'b0, "R8", "valid in done cycle", pix_valid, 0);
  endtask

  // host-side constant computation from endpoints
  task automatic host_line(input int sx, input int sy, input int ex, input int ey,
                           input bit lo, input bit de);
    int dx, dy, mn, mx, e0;
    bit my;
    dx = (ex >= sx) ? ex - sx : sx - ex;
    dy = (ey >= sy) ? ey - sy : sy - ey;
    my = dy > dx;
    mn = my ? dx : dy;
    mx = my ? dy : dx;
    e0 = 2 * mn - mx - ((sx < ex) ? 1 : 0);
    launch(CW'(sx), CW'(sy), CW'(2 * mn), CW'(2 * (mn - mx)), CW'(e0), mx + 1,
           my, ex >= sx, ey >= sy, lo, de);
  endtask

  initial begin
    #700000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(pix_valid == 1'b0, "R1", "pix_valid after reset", pix_valid, 0);
    chk(done == 1'b0, "R1", "done after reset", done, 0);

    // R2 R3: shallow line right-down
    host_line(10, 20, 17, 23, 1'b0, 1'b1); check_walk(-1);
    // R3 R5: steep line up-left, Y major
    host_line(50, 60, 46, 49, 1'b0, 1'b1); check_walk(-1);
    // R6: last pixel suppressed
    host_line(0, 0, 4, 2, 1'b1, 1'b1); check_walk(-1);
    // R6: single-pixel line with last_off gives nothing valid
    launch(16'd5, 16'd5, 16'd0, 16'd0, 16'd0, 1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1); check_walk(-1);
    // R7: move only
    host_line(100, 100, 90, 107, 1'b0, 1'b0); check_walk(-1);
    // R10: zero length
    launch(16'd1, 16'd2, 16'd3, 16'hFFF0, 16'd0, 0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1); check_walk(-1);
    // R9: start mid-walk ignored
    host_line(30, 30, 36, 33, 1'b0, 1'b1); check_walk(1);
    // R8: start in the done cycle is accepted (chained lines)
    host_line(0, 0, 5, 5, 1'b0, 1'b1); check_walk(-1);
    host_line(200, 10, 195, 30, 1'b0, 1'b1); check_walk(-1);
    // R11: wrap across the sign boundary
    launch(16'h7FFF, 16'hFFFF, 16'd2, 16'hFFFC, 16'd0, 3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1); check_walk(-1);
    // R4: pure axial and pure diagonal error patterns
    launch(16'd9, 16'd9, 16'd0, 16'd0, 16'h8000, 5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1); check_walk(-1);
    launch(16'd9, 16'd9, 16'd0, 16'd0, 16'd0, 5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1); check_walk(-1);

    for (int t = 0; t < 60; t++) begin
      if (t % 2 == 0) begin
        host_line(int'($urandom_range(0, 300)), int'($urandom_range(0, 300)),
                  int'($urandom_range(0, 300)) % 24 + 150, int'($urandom_range(0, 300)) % 24 + 150,
                  1'($urandom), ($urandom_range(0, 3) != 0));
      end else begin
        launch(CW'($urandom), CW'($urandom), CW'($urandom_range(0, 40)),
               CW'(-int'($urandom_range(0, 40))), CW'(int'($urandom_range(0, 60)) - 30),
               int'($urandom_range(0, 24)), 1'($urandom), 1'($urandom), 1'($urandom),
               1'($urandom), ($urandom_range(0, 3) != 0));
      end
      check_walk((m_len > 3 && t % 5 == 0) ? 2 : -1);
    end

    @(posedge clk); @(negedge clk);
    chk(done == 1'b0, "R8", "done one cycle only", done, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule